// File: doc/BRIEF.md
# Endian-Aware Bus Byte-Lane Steering Unit

This block sits between a processor core's load/store path and an external data bus whose width is set at run time to 8, 16 or 32 bits. A request gives a value, a data type (byte, half word, word or a run of words), an aligned start address and a byte-order select. The block breaks the request into bus beats. For each beat it drives the beat address, puts each value byte on the byte lane that its memory address selects, and raises one byte enable per lane that carries data. It moves to the next beat only when the bus reports ready.

The byte-order select decides which value byte belongs at each memory address. In little-endian order the least significant byte goes to the lowest address. In big-endian order the most significant byte goes there. A run of words is always handled as a series of word accesses. The word in the lowest bits of the value goes to the lowest address, and the selected byte order applies only inside each word.

Loads use the same beat sequence in reverse. The bytes that arrive are put back into a right-justified register value. Misaligned or malformed requests are refused with an error pulse, and no bus activity follows.

Top module: `byte_lane_steer`

## Requirements
- R1: A request is taken when `req_valid` is high and `busy` is low. Type codes are 0 = byte, 1 = half word, 2 = word, 3 = run of `req_nwords` words. Bus codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. `cfg_big` = 1 selects big-endian. `busy` rises the cycle after a legal request is taken and stays high until the last beat is accepted.
- R2: A byte goes out in one beat at its own address, on lane (address mod bus bytes). Its placement is the same in both byte orders.
- R3: On the 32-bit bus, the word 0xAABBCCDD at address 0 is one beat. Little-endian gives bus_wdata 0xAABBCCDD. Big-endian gives 0xDDCCBBAA.
- R4: On the 16-bit bus, a word is two beats, at address +0 and then +2. Little-endian sends lanes 1:0 = CC,DD and then AA,BB. Big-endian sends lanes 1:0 = BB,AA and then DD,CC.
- R5: On the 8-bit bus, a word is four beats at address +0, +1, +2 and +3, all on lane 0. Little-endian order is DD, CC, BB, AA. Big-endian order is AA, BB, CC, DD.
- R6: On the 32-bit bus, a half word uses lanes 1:0 when address bit 1 is 0 and lanes 3:2 when it is 1. In big-endian order its low byte sits on the higher of the two lanes. On the 16-bit bus it takes one beat; on the 8-bit bus it takes two.
- R7: A run of N words goes to addresses A, A+4, and so on. Word k is value bits 32k+31:32k. Each word is laid out as a single word in the selected byte order.
- R8: Each beat sets exactly the byte enables (bit i = lane i, lane i = bus bits 8i+7:8i) of the lanes that carry data. Every other lane of bus_wdata is zero. bus_wdata is all zero during loads, and enables and data are zero when no beat is pending.
- R9: A beat's address, enables and data stay unchanged until `bus_rdy` is sampled high. The next beat follows in the cycle after that.
- R10: `done` is a one-cycle pulse in the cycle after the final beat is accepted. In that same cycle `busy` is low.
- R11: A load rebuilds the value by the inverse of the store mapping. When `done` pulses, `rd_data` holds it right-justified, with unused upper bytes zero. Disabled lanes of bus_rdata have no effect.
- R12: A request is refused if it is a half word with address bit 0 set, a word or run with address bits 1:0 not 00, a run of 0 words or more than MAX_WORDS words, or a bus code of 3. A refused request gives a one-cycle `err` pulse the cycle after it is presented, with no bus beat and no `done`.
- R13: A request presented while `busy` is high is ignored. The transfer in progress goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_we | input | 1 | 1 = store, 0 = load |
| req_type | input | 2 | Data type code |
| req_nwords | input | NW_W | Word count for a run of words |
| req_addr | input | ADDR_W | Start address |
| req_wdata | input | 32*MAX_WORDS | Store value, right-justified |
| cfg_big | input | 1 | Byte order, 1 = big-endian |
| cfg_bus | input | 2 | Bus width code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Request finished pulse |
| err | output | 1 | Request refused pulse |
| rd_data | output | 32*MAX_WORDS | Load result, right-justified |
| bus_req | output | 1 | Beat pending |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Beat address |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes |
| bus_rdy | input | 1 | Bus accepts current beat |

## Verification
Each data type is sent on each bus width in both byte orders, using a value whose bytes are all different. A swapped lane, a reversed beat order or a wrong beat address therefore shows up as a distinct byte mismatch. Half words are placed at both halves of a word, so the lane choice made by address bit 1 is checked against the byte swap. Two-word runs on every bus width separate the big-endian order inside a word from the little-endian order between words. Loads return bytes derived from the address on every lane, including disabled ones, so wrong packing or use of a disabled lane is caught. A regular stall pattern on the ready input exercises holding a beat, and illegal requests and requests made while busy check refusal and ignoring.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [1:0] {DT_BYTE = 2'd0, DT_HALF = 2'd1, DT_WORD = 2'd2, DT_RUN = 2'd3} dtype_e;
   typedef enum logic [1:0] {BW_8 = 2'd0, BW_16 = 2'd1, BW_32 = 2'd2, BW_BAD = 2'd3} bwidth_e;
   localparam int LANES = 4;
endpackage

// File: rtl/bls_align_chk.sv
module bls_align_chk
   import bls_pkg::*;
#(
   parameter int MAX_WORDS = 2,
   parameter int NW_W      = $clog2(MAX_WORDS + 1)
) (
   input  dtype_e             typ,
   input  logic [NW_W-1:0]    nwords,
   input  logic [1:0]         alo,
   input  bwidth_e            bw,
   output logic               bad
);
   always_comb begin
      bad = (bw == BW_BAD);
      unique case (typ)
         DT_HALF: bad = bad | alo[0];
         DT_WORD: bad = bad | (|alo);
         DT_RUN:  bad = bad | (|alo) | (nwords == '0) | (nwords > NW_W'(MAX_WORDS));
         default: ;
      endcase
   end
endmodule

// File: rtl/bls_lane_map.sv
module bls_lane_map
   import bls_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_WORDS = 2,
   localparam int VAL_B    = 4 * MAX_WORDS,
   localparam int IDX_W    = $clog2(VAL_B),
   localparam int OW       = $clog2(VAL_B + 1) + 1,
   localparam int NW_W     = $clog2(MAX_WORDS + 1)
) (
   input  dtype_e                      typ,
   input  logic [NW_W-1:0]             nwords,
   input  logic [ADDR_W-1:0]           base_addr,
   input  logic                        big,
   input  bwidth_e                     bw,
   input  logic                        we,
   input  logic [OW-1:0]               beat,
   input  logic [8*VAL_B-1:0]          val,
   output logic [LANES-1:0]            lane_en,
   output logic [LANES-1:0][IDX_W-1:0] lane_src,
   output logic [8*LANES-1:0]          lane_wd,
   output logic [ADDR_W-1:0]           beat_addr,
   output logic                        last
);
   logic [OW-1:0] n_bytes, unit, bus_b, chunk, step;
   logic [1:0]    phase;

   always_comb begin
      unique case (typ)
         DT_BYTE: begin n_bytes = OW'(1); unit = OW'(1); end
         DT_HALF: begin n_bytes = OW'(2); unit = OW'(2); end
         DT_WORD: begin n_bytes = OW'(4); unit = OW'(4); end
         default: begin n_bytes = OW'({nwords, 2'b00}); unit = OW'(4); end
      endcase
      bus_b     = OW'(1) << bw;
      chunk     = (n_bytes < bus_b) ? n_bytes : bus_b;
      step      = beat * chunk;
      last      = (step + chunk) >= n_bytes;
      beat_addr = base_addr + ADDR_W'(step);
      phase     = beat_addr[1:0] & 2'(bus_b - OW'(1));
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [OW-1:0]    rel, off, um, vb;
      logic             on;
      logic [IDX_W-1:0] src;
      always_comb begin
         rel = OW'(l) - OW'(phase);
         on  = (OW'(l) < bus_b) && (2'(l) >= phase) && (rel < chunk);
         off = step + rel;
         um  = unit - OW'(1);
         vb  = big ? ((off & ~um) | (um - (off & um))) : off;
         src = IDX_W'(vb);
      end
      assign lane_en[l]       = on;
      assign lane_src[l]      = src;
      assign lane_wd[8*l +: 8] = (on && we) ? val[{src, 3'b000} +: 8] : 8'h00;
   end
endmodule

// File: rtl/bls_beat_ctrl.sv
module bls_beat_ctrl #(
   parameter int OW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          last,
   input  logic          bus_rdy,
   output logic          busy,
   output logic [OW-1:0] beat,
   output logic          done
);
   typedef enum logic {S_IDLE = 1'b0, S_XFER = 1'b1} st_e;
   st_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         beat <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == S_IDLE) begin
            if (start) begin
               st   <= S_XFER;
               beat <= '0;
            end
         end else if (bus_rdy) begin
            if (last) begin
               st   <= S_IDLE;
               done <= 1'b1;
            end else begin
               beat <= beat + OW'(1);
            end
         end
      end
   end

   assign busy = (st == S_XFER);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R9
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bus_rdy |=> busy && $stable(beat));
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
   import bls_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_WORDS = 2,
   localparam int VAL_W    = 32 * MAX_WORDS,
   localparam int VAL_B    = 4 * MAX_WORDS,
   localparam int IDX_W    = $clog2(VAL_B),
   localparam int OW       = $clog2(VAL_B + 1) + 1,
   localparam int NW_W     = $clog2(MAX_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [1:0]        req_type,
   input  logic [NW_W-1:0]   req_nwords,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [VAL_W-1:0]  req_wdata,
   input  logic              cfg_big,
   input  logic [1:0]        cfg_bus,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [VAL_W-1:0]  rd_data,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_be,
   output logic [31:0]       bus_wdata,
   input  logic [31:0]       bus_rdata,
   input  logic              bus_rdy
);
   if (MAX_WORDS < 1) begin : g_bad_words
      $error("MAX_WORDS must be at least 1");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   dtype_e                      q_type;
   bwidth_e                     q_bw;
   logic [NW_W-1:0]             q_nw;
   logic [ADDR_W-1:0]           q_addr;
   logic [VAL_W-1:0]            q_val, rd_q;
   logic                        q_big, q_we, err_q, bad, take;
   logic [OW-1:0]               beat;
   logic                        last;
   logic [LANES-1:0]            lane_en;
   logic [LANES-1:0][IDX_W-1:0] lane_src;
   logic [31:0]                 lane_wd;
   logic [ADDR_W-1:0]           beat_addr;

   bls_align_chk #(.MAX_WORDS(MAX_WORDS), .NW_W(NW_W)) u_chk (
      .typ(dtype_e'(req_type)), .nwords(req_nwords), .alo(req_addr[1:0]),
      .bw(bwidth_e'(cfg_bus)), .bad(bad));

   assign take = req_valid && !busy;

   bls_beat_ctrl #(.OW(OW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(take && !bad), .last(last),
      .bus_rdy(bus_rdy), .busy(busy), .beat(beat), .done(done));

   bls_lane_map #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_map (
      .typ(q_type), .nwords(q_nw), .base_addr(q_addr), .big(q_big), .bw(q_bw),
      .we(q_we), .beat(beat), .val(q_val), .lane_en(lane_en), .lane_src(lane_src),
      .lane_wd(lane_wd), .beat_addr(beat_addr), .last(last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_type <= DT_BYTE;
         q_bw   <= BW_8;
         q_nw   <= '0;
         q_addr <= '0;
         q_val  <= '0;
         q_big  <= 1'b0;
         q_we   <= 1'b0;
         err_q  <= 1'b0;
         rd_q   <= '0;
      end else begin
         err_q <= take && bad;
         if (take && !bad) begin
            q_type <= dtype_e'(req_type);
            q_bw   <= bwidth_e'(cfg_bus);
            q_nw   <= req_nwords;
            q_addr <= req_addr;
            q_val  <= req_wdata;
            q_big  <= cfg_big;
            q_we   <= req_we;
            if (!req_we) rd_q <= '0;
         end
         if (busy && bus_rdy && !q_we) begin
            for (int l = 0; l < LANES; l++) begin
               if (lane_en[l]) rd_q[{lane_src[l], 3'b000} +: 8] <= bus_rdata[8*l +: 8];
            end
         end
      end
   end

   assign err       = err_q;
   assign rd_data   = rd_q;
   assign bus_req   = busy;
   assign bus_we    = busy && q_we;
   assign bus_addr  = busy ? beat_addr : '0;
   assign bus_be    = busy ? lane_en : 4'h0;
   assign bus_wdata = busy ? lane_wd : 32'h0;

   function automatic logic [31:0] be_mask(input logic [3:0] be);
      for (int i = 0; i < 4; i++) be_mask[8*i +: 8] = {8{be[i]}};
   endfunction

   // R8
   be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> bus_be != 4'h0);
   // R8
   quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wdata & ~be_mask(bus_be)) == 32'h0);
   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata));
   // R12
   err_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> !bus_req && !done);
   // R5
   narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && (q_bw == BW_8) |-> bus_be == 4'b0001);
endmodule

// File: tb/tb_byte_lane_steer.sv
module tb_byte_lane_steer;
   localparam int CLK_P = 10;
   localparam int AW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0, cfg_big = 1'b0, bus_rdy = 1'b0;
   logic [1:0]  req_type = '0, cfg_bus = '0, req_nwords = '0;
   logic [AW-1:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [31:0] bus_rdata = '0;
   logic        busy, done, err, bus_req, bus_we;
   logic [63:0] rd_data;
   logic [AW-1:0] bus_addr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata;

   int vectors = 0, fails = 0, stall_ctr = 0;

   always #(CLK_P/2) clk = ~clk;

   byte_lane_steer dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_type(req_type), .req_nwords(req_nwords), .req_addr(req_addr),
      .req_wdata(req_wdata), .cfg_big(cfg_big), .cfg_bus(cfg_bus), .busy(busy),
      .done(done), .err(err), .rd_data(rd_data), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rdy(bus_rdy));

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(int a);
      return 8'((a * 29 + 90) & 255);
   endfunction

   task automatic xfer(string tag, int typ, int nw, int addr, bit big, int bw,
                       bit we, logic [63:0] val, bit poke);
      int n, u, w, chunk, nb, k;
      bit bad, rdy;
      logic [7:0]  img[8];
      logic [63:0] exp_rd;
      n = (typ == 0) ? 1 : (typ == 1) ? 2 : (typ == 2) ? 4 : 4 * nw;
      u = (typ == 3) ? 4 : n;
      bad = (bw == 3) || (typ == 1 && addr % 2 != 0) || (typ >= 2 && addr % 4 != 0)
            || (typ == 3 && (nw < 1 || nw > 2));
      exp_rd = '0;
      for (int o = 0; o < n && o < 8; o++) begin
         int vb;
         vb = big ? (o / u) * u + (u - 1 - o % u) : o;
         img[o] = val[8*vb +: 8];
         exp_rd[8*vb +: 8] = mem_byte(addr + o);
      end
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_type = 2'(typ); req_nwords = 2'(nw);
      req_addr = AW'(addr); req_wdata = val; cfg_big = big; cfg_bus = 2'(bw);
      @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
         check(tag, "err", err, 1);
         check(tag, "bus_req after refuse", bus_req, 0);
         check(tag, "busy after refuse", busy, 0);
         @(negedge clk);
         check(tag, "err pulse end", err, 0);
         check(tag, "no done", done, 0);
         check(tag, "no beat", bus_req, 0);
         return;
      end
      check("R1", "busy", busy, 1);
      w = 1 << bw;
      chunk = (n < w) ? n : w;
      nb = n / chunk;
      k = 0;
      while (k < nb) begin
         int a, ph;
         logic [3:0]  ebe;
         logic [31:0] ed;
         a = addr + k * chunk;
         ph = a % w;
         ebe = 4'(((1 << chunk) - 1) << ph);
         ed = '0;
         if (we) for (int l = ph; l < ph + chunk; l++) ed[8*l +: 8] = img[k*chunk + l - ph];
         check({tag, "/R9"}, "bus_req", bus_req, 1);
         check({tag, "/R9"}, "addr", bus_addr, AW'(a));
         check("R8", "be", bus_be, ebe);
         check(tag, "wdata", bus_wdata, ed);
         check("R10", "done early", done, 0);
         stall_ctr++;
         rdy = (stall_ctr % 4) != 2;
         bus_rdy = rdy;
         for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = mem_byte(a - ph + l);
         if (poke && k == 0) begin
            // R13: new request while busy must be ignored
            req_valid = 1'b1; req_type = 2'd0; req_addr = 32'h40; req_wdata = '1;
            cfg_bus = 2'd2; cfg_big = ~big; req_we = 1'b1;
         end
         @(negedge clk);
         req_valid = 1'b0;
         if (rdy) k++;
      end
      bus_rdy = 1'b0;
      check("R10", "done", done, 1);
      check("R10", "busy at done", busy, 0);
      if (!we) check({tag, "/R11"}, "rd_data", rd_data, exp_rd);
      @(negedge clk);
      check("R10", "done one cycle", done, 0);
      check("R8", "idle be", bus_be, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "reset busy", busy, 0);
      check("R1", "reset bus_req", bus_req, 0);
      check("R8", "reset be", bus_be, 0);
      check("R10", "reset done", done, 0);
      check("R12", "reset err", err, 0);
      rst_n = 1'b1;
      // stores: R2 .. R7
      xfer("R2", 0, 0, 3, 0, 2, 1, 64'hDD, 0);
      xfer("R2", 0, 0, 3, 1, 2, 1, 64'hDD, 0);
      xfer("R2", 0, 0, 5, 1, 1, 1, 64'h5E, 0);
      xfer("R3", 2, 0, 0, 0, 2, 1, 64'hAABBCCDD, 0);
      xfer("R3", 2, 0, 0, 1, 2, 1, 64'hAABBCCDD, 0);
      xfer("R4", 2, 0, 8, 0, 1, 1, 64'hAABBCCDD, 0);
      xfer("R4", 2, 0, 8, 1, 1, 1, 64'hAABBCCDD, 0);
      xfer("R5", 2, 0, 4, 0, 0, 1, 64'hAABBCCDD, 0);
      xfer("R5", 2, 0, 4, 1, 0, 1, 64'hAABBCCDD, 0);
      xfer("R6", 1, 0, 0, 0, 2, 1, 64'hCCDD, 0);
      xfer("R6", 1, 0, 2, 0, 2, 1, 64'hCCDD, 0);
      xfer("R6", 1, 0, 2, 1, 2, 1, 64'hCCDD, 0);
      xfer("R6", 1, 0, 6, 1, 1, 1, 64'hCCDD, 0);
      xfer("R6", 1, 0, 6, 1, 0, 1, 64'hCCDD, 0);
      xfer("R7", 3, 2, 16, 1, 2, 1, 64'h1122334455667788, 0);
      xfer("R7", 3, 2, 16, 1, 1, 1, 64'h1122334455667788, 0);
      xfer("R7", 3, 2, 16, 1, 0, 1, 64'h1122334455667788, 0);
      xfer("R7", 3, 2, 16, 0, 1, 1, 64'h1122334455667788, 0);
      xfer("R7", 3, 1, 20, 1, 2, 1, 64'h99AABBCC, 0);
      // loads: R11
      xfer("R11", 2, 0, 12, 1, 1, 0, '0, 0);
      xfer("R11", 1, 0, 10, 1, 2, 0, '0, 0);
      xfer("R11", 0, 0, 7, 0, 0, 0, '0, 0);
      xfer("R11", 3, 2, 32, 1, 0, 0, '0, 0);
      xfer("R11", 2, 0, 36, 0, 2, 0, '0, 0);
      // refusals: R12
      xfer("R12", 1, 0, 1, 0, 2, 1, 64'h1234, 0);
      xfer("R12", 2, 0, 2, 1, 2, 1, 64'h1234, 0);
      xfer("R12", 3, 0, 0, 1, 2, 1, 64'h1234, 0);
      xfer("R12", 3, 3, 0, 1, 2, 1, 64'h1234, 0);
      xfer("R12", 0, 0, 0, 0, 3, 1, 64'h12, 0);
      // busy ignore: R13
      xfer("R13", 2, 0, 24, 1, 0, 1, 64'hAABBCCDD, 1);
      xfer("R13", 3, 2, 40, 1, 1, 0, '0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule